// File: doc/BRIEF.md
# Trap Entry Controller

This block works next to a 32-bit in-order core and decides, in the same cycle as a request, whether and how the core enters a trap. There are four request classes: a hardware exception, a memory-management fault, a break and an external interrupt. When one is accepted, the block supplies the vector PC, a write of the return address into the link register that belongs to that class, and the new status word. The status word carries the in-progress flags and the saved privilege and translation mode. The block also drives pulses that drop the load-reserved reservation and wipe the instruction-context flags.

The block owns three registers: the syndrome, the fault address and the branch target. These take their new values at the clock edge that ends the accepting cycle. The status word is held by the core: the core feeds it in on `msr_in` and writes back `msr_out` when `take` is high.

A small state machine tracks management-fault handling. `ST_RUN` is normal operation. A management-fault entry moves the machine to `ST_MMU_OPEN`, where it stays while the exception-in-progress bit of `msr_in` is set. It returns to `ST_RUN` when that bit is seen clear. If a second management fault arrives in `ST_MMU_OPEN` while the bit is still set, the machine moves to `ST_FATAL`. That state accepts nothing until reset.

Top module: `trap_entry_ctrl`

## Requirements
- R1: On an accepted entry `pc_next` is the vector base plus 0x10 for an interrupt, 0x18 for a break, and 0x20 for a hardware exception or a management fault. `entry_kind` encodes interrupt=0, break=1, hardware exception=2, management fault=3.
- R2: `link_we` is high exactly when `take` is high. The link index is 14 for an interrupt and 16 for a break, each holding the current PC. It is 17 for a hardware exception, holding PC+4.
- R3: A management fault writes index 17 with the rewound address. This is PC-8 when `ctx_dslot` and `ctx_bimm` are both set, PC-4 when only `ctx_dslot` is set or when `ctx_imm` is set, and PC otherwise.
- R4: An interrupt is accepted only when all of these hold: status bit 1 (interrupt enable) is set, bit 9 (exception in progress) is clear, bit 3 (break in progress) is clear, and neither `ctx_dslot` nor `ctx_imm` is set. Accepting it clears bit 1 in `msr_out`.
- R5: Hardware-exception and management-fault entries set bit 9 in `msr_out`. A break entry sets bit 3.
- R6: On every entry, `msr_out` bit 12 receives input bit 11 (user mode) and bit 14 receives input bit 13 (translation enable). Bits 11 and 13 are cleared. Without an entry, `msr_out` equals `msr_in`.
- R7: After a hardware-exception or management-fault entry, syndrome bit 12 equals `ctx_dslot`. The branch-target register loads `branch_tgt` only when `ctx_dslot` was set, and otherwise keeps its value.
- R8: After a management-fault entry, syndrome bits [4:0] are 16 for a data protection fault, 17 for a fetch protection fault, 18 for a data miss and 19 for a fetch miss. Bit 10 is set for a store. The fault-address register holds `fault_addr`. `acc_type` encodes load=0, store=1, fetch=2. After a hardware-exception entry, bits [4:0] hold `hwexc_cause`.
- R9: A management fault raised in `ST_MMU_OPEN` while status bit 9 is set leads to `ST_FATAL`. In that state `fatal_recursive` is high from the next edge on, and no entry is accepted until reset.
- R10: `resv_clear` and `ctx_clear` are high in every cycle with an accepted entry, and only then.
- R11: With several requests eligible in one cycle, the order of precedence is hardware exception, then management fault, then break, then interrupt. At most one entry is made per cycle.
- R12: A hardware-exception request has no effect while `exc_supported` is low. Interrupt and break entries leave the syndrome and fault-address registers unchanged.
- R13: When status bit 9 reads clear in `ST_MMU_OPEN`, a new management fault is accepted as a normal entry and does not count as recursive.
- R14: After reset `take` is low, the syndrome, fault-address and branch-target registers are zero, and `fatal_recursive` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_supported | input | 1 | Configuration: hardware exceptions exist |
| req_hwexc | input | 1 | Hardware exception request |
| hwexc_cause | input | 5 | Cause code for a hardware exception |
| req_mmu | input | 1 | Management fault request |
| mmu_is_miss | input | 1 | 1 = translation miss, 0 = protection fault |
| acc_type | input | 2 | Faulting access: 0 load, 1 store, 2 fetch |
| fault_addr | input | 32 | Faulting address |
| req_brk | input | 1 | Break request |
| req_irq | input | 1 | External interrupt request |
| cur_pc | input | 32 | PC of the current instruction |
| branch_tgt | input | 32 | Pending branch target |
| msr_in | input | 32 | Current status word |
| ctx_dslot | input | 1 | Current instruction sits in a delay slot |
| ctx_imm | input | 1 | Current instruction follows an immediate prefix |
| ctx_bimm | input | 1 | The delay-slot branch carried an immediate prefix |
| take | output | 1 | An entry is made this cycle |
| entry_kind | output | 2 | Class of the entry made |
| pc_next | output | 32 | Vector PC |
| link_we | output | 1 | Link register write enable |
| link_idx | output | 5 | Link register index |
| link_data | output | 32 | Return address to write |
| msr_out | output | 32 | Updated status word |
| esr_q | output | 32 | Syndrome register |
| ear_q | output | 32 | Fault-address register |
| btr_q | output | 32 | Branch-target register |
| resv_clear | output | 1 | Drop the load reservation |
| ctx_clear | output | 1 | Clear all instruction-context flags |
| fatal_recursive | output | 1 | Recursive management fault detected |

## Verification
Most of the logic is combinational, so a wrong arbitration or gating decision shows at once on `take`, `entry_kind` and `msr_out`, within the cycle of the request. A wrong state-machine state shows only when a second management fault arrives. A missed transition to `ST_FATAL` lets an entry through where none is due, and `fatal_recursive` stays low one edge later. A transition to `ST_FATAL` taken in error raises `fatal_recursive` and then blocks every later request. Syndrome, fault-address and branch-target faults show one edge after the entry, or when a later interrupt or break entry alters a value it should keep.

// File: rtl/trap_pkg.sv
package trap_pkg;

    localparam int XLEN    = 32;
    localparam int REGW    = 5;
    localparam int CAUSE_W = 5;

    // status word bit positions; saved copies sit one above their live bit
    localparam int MSR_IE  = 1;
    localparam int MSR_BIP = 3;
    localparam int MSR_EIP = 9;
    localparam int MSR_UM  = 11;
    localparam int MSR_VM  = 13;
    localparam int N_MODE  = 2;

    // syndrome bit positions
    localparam int ESR_STORE = 10;
    localparam int ESR_DS    = 12;

    // link register indices
    localparam logic [REGW-1:0] LINK_IRQ = REGW'(14);
    localparam logic [REGW-1:0] LINK_BRK = REGW'(16);
    localparam logic [REGW-1:0] LINK_EXC = REGW'(17);

    // vector offsets
    localparam int OFF_IRQ = 'h10;
    localparam int OFF_BRK = 'h18;
    localparam int OFF_EXC = 'h20;

    // management fault base code; +2 for a miss, +1 for a fetch
    localparam int MMU_CODE_BASE = 16;

    typedef enum logic [1:0] {
        K_IRQ   = 2'd0,
        K_BRK   = 2'd1,
        K_HWEXC = 2'd2,
        K_MMU   = 2'd3
    } trap_kind_e;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    typedef enum logic [1:0] {
        ST_RUN      = 2'd0,
        ST_MMU_OPEN = 2'd1,
        ST_FATAL    = 2'd2
    } ctl_state_e;

    function automatic int mode_bit(input int i);
        return (i == 0) ? MSR_UM : MSR_VM;
    endfunction

endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
    import trap_pkg::*;
#(
    parameter int XW = XLEN
) (
    input  logic          exc_supported,
    input  logic          req_hwexc,
    input  logic          req_mmu,
    input  logic          req_brk,
    input  logic          req_irq,
    input  logic [XW-1:0] msr_in,
    input  logic          ctx_dslot,
    input  logic          ctx_imm,
    input  logic          blocked,
    input  logic          mmu_busy,
    output logic          take,
    output trap_kind_e    kind,
    output logic          recursive_hit
);

    logic hw_ok;
    logic irq_ok;

    always_comb begin
        hw_ok  = req_hwexc && exc_supported;
        irq_ok = req_irq && msr_in[MSR_IE] && !msr_in[MSR_EIP]
                 && !msr_in[MSR_BIP] && !ctx_dslot && !ctx_imm;
    end

    always_comb begin
        take          = 1'b0;
        kind          = K_IRQ;
        recursive_hit = 1'b0;
        if (!blocked) begin
            if (hw_ok) begin
                take = 1'b1;
                kind = K_HWEXC;
            end else if (req_mmu) begin
                if (mmu_busy) begin
                    recursive_hit = 1'b1;
                end else begin
                    take = 1'b1;
                    kind = K_MMU;
                end
            end else if (req_brk) begin
                take = 1'b1;
                kind = K_BRK;
            end else if (irq_ok) begin
                take = 1'b1;
                kind = K_IRQ;
            end
        end
    end

endmodule

// File: rtl/trap_target_calc.sv
module trap_target_calc
    import trap_pkg::*;
#(
    parameter int            XW       = XLEN,
    parameter logic [XW-1:0] VEC_BASE = '0
) (
    input  trap_kind_e      kind,
    input  logic [XW-1:0]   pc,
    input  logic            dslot,
    input  logic            imm,
    input  logic            bimm,
    output logic [XW-1:0]   vec_pc,
    output logic [REGW-1:0] link_idx,
    output logic [XW-1:0]   link_val
);

    localparam logic [XW-1:0] WORD  = XW'(4);
    localparam logic [XW-1:0] DWORD = XW'(8);

    logic [XW-1:0] mmu_ret;

    always_comb begin
        if (dslot) begin
            mmu_ret = bimm ? (pc - DWORD) : (pc - WORD);
        end else if (imm) begin
            mmu_ret = pc - WORD;
        end else begin
            mmu_ret = pc;
        end
    end

    always_comb begin
        unique case (kind)
            K_IRQ: begin
                vec_pc   = VEC_BASE + XW'(OFF_IRQ);
                link_idx = LINK_IRQ;
                link_val = pc;
            end
            K_BRK: begin
                vec_pc   = VEC_BASE + XW'(OFF_BRK);
                link_idx = LINK_BRK;
                link_val = pc;
            end
            K_HWEXC: begin
                vec_pc   = VEC_BASE + XW'(OFF_EXC);
                link_idx = LINK_EXC;
                link_val = pc + WORD;
            end
            default: begin
                vec_pc   = VEC_BASE + XW'(OFF_EXC);
                link_idx = LINK_EXC;
                link_val = mmu_ret;
            end
        endcase
    end

endmodule

// File: rtl/trap_status_upd.sv
module trap_status_upd
    import trap_pkg::*;
#(
    parameter int XW = XLEN
) (
    input  logic          take,
    input  trap_kind_e    kind,
    input  logic [XW-1:0] msr_in,
    output logic [XW-1:0] msr_out
);

    logic [XW-1:0] flag_set;
    logic [XW-1:0] mode_push;
    logic [XW-1:0] mode_keep;

    always_comb begin
        flag_set = msr_in;
        unique case (kind)
            K_IRQ:   flag_set[MSR_IE]  = 1'b0;
            K_BRK:   flag_set[MSR_BIP] = 1'b1;
            default: flag_set[MSR_EIP] = 1'b1;
        endcase
    end

    for (genvar g = 0; g < N_MODE; g++) begin : g_mode
        localparam int LIVE = mode_bit(g);
        assign mode_push[LIVE+1] = flag_set[LIVE];
        assign mode_push[LIVE]   = 1'b0;
        assign mode_keep[LIVE+1] = 1'b0;
        assign mode_keep[LIVE]   = 1'b0;
    end

    for (genvar b = 0; b < XW; b++) begin : g_bits
        if (b != MSR_UM && b != MSR_UM + 1 && b != MSR_VM && b != MSR_VM + 1) begin : g_plain
            assign mode_push[b] = 1'b0;
            assign mode_keep[b] = 1'b1;
        end
    end

    always_comb begin
        msr_out = take ? ((flag_set & mode_keep) | mode_push) : msr_in;
    end

endmodule

// File: rtl/trap_syndrome_regs.sv
module trap_syndrome_regs
    import trap_pkg::*;
#(
    parameter int XW = XLEN,
    parameter int CW = CAUSE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  trap_kind_e    kind,
    input  logic          dslot,
    input  logic [XW-1:0] btarget,
    input  logic [CW-1:0] hw_cause,
    input  logic          is_miss,
    input  logic [1:0]    acc,
    input  logic [XW-1:0] fault_addr,
    output logic [XW-1:0] esr_q,
    output logic [XW-1:0] ear_q,
    output logic [XW-1:0] btr_q
);

    logic          is_exc;
    logic [XW-1:0] esr_d;
    logic [CW-1:0] mmu_code;

    always_comb begin
        is_exc   = take && (kind == K_HWEXC || kind == K_MMU);
        mmu_code = CW'(MMU_CODE_BASE) + (is_miss ? CW'(2) : CW'(0))
                   + ((acc == ACC_FETCH) ? CW'(1) : CW'(0));
        esr_d    = '0;
        esr_d[ESR_DS] = dslot;
        if (kind == K_MMU) begin
            esr_d[CW-1:0]    = mmu_code;
            esr_d[ESR_STORE] = (acc == ACC_STORE);
        end else begin
            esr_d[CW-1:0] = hw_cause;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            esr_q <= '0;
            ear_q <= '0;
            btr_q <= '0;
        end else if (is_exc) begin
            esr_q <= esr_d;
            if (dslot) begin
                btr_q <= btarget;
            end
            if (kind == K_MMU) begin
                ear_q <= fault_addr;
            end
        end
    end

endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
    import trap_pkg::*;
#(
    parameter int              XW       = XLEN,
    parameter int              CW       = CAUSE_W,
    parameter logic [XLEN-1:0] VEC_BASE = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            exc_supported,
    input  logic            req_hwexc,
    input  logic [CW-1:0]   hwexc_cause,
    input  logic            req_mmu,
    input  logic            mmu_is_miss,
    input  logic [1:0]      acc_type,
    input  logic [XW-1:0]   fault_addr,
    input  logic            req_brk,
    input  logic            req_irq,
    input  logic [XW-1:0]   cur_pc,
    input  logic [XW-1:0]   branch_tgt,
    input  logic [XW-1:0]   msr_in,
    input  logic            ctx_dslot,
    input  logic            ctx_imm,
    input  logic            ctx_bimm,
    output logic            take,
    output logic [1:0]      entry_kind,
    output logic [XW-1:0]   pc_next,
    output logic            link_we,
    output logic [REGW-1:0] link_idx,
    output logic [XW-1:0]   link_data,
    output logic [XW-1:0]   msr_out,
    output logic [XW-1:0]   esr_q,
    output logic [XW-1:0]   ear_q,
    output logic [XW-1:0]   btr_q,
    output logic            resv_clear,
    output logic            ctx_clear,
    output logic            fatal_recursive
);

    localparam logic [XW-1:0] BASE = XW'(VEC_BASE);

    ctl_state_e state_q, state_d;
    trap_kind_e kind;
    logic       arb_take;
    logic       recursive_hit;
    logic       blocked;
    logic       mmu_busy;

    always_comb begin
        blocked  = (state_q == ST_FATAL);
        mmu_busy = (state_q == ST_MMU_OPEN) && msr_in[MSR_EIP];
    end

    trap_arbiter #(.XW(XW)) u_arb (
        .exc_supported (exc_supported),
        .req_hwexc     (req_hwexc),
        .req_mmu       (req_mmu),
        .req_brk       (req_brk),
        .req_irq       (req_irq),
        .msr_in        (msr_in),
        .ctx_dslot     (ctx_dslot),
        .ctx_imm       (ctx_imm),
        .blocked       (blocked),
        .mmu_busy      (mmu_busy),
        .take          (arb_take),
        .kind          (kind),
        .recursive_hit (recursive_hit)
    );

    trap_target_calc #(.XW(XW), .VEC_BASE(BASE)) u_tgt (
        .kind     (kind),
        .pc       (cur_pc),
        .dslot    (ctx_dslot),
        .imm      (ctx_imm),
        .bimm     (ctx_bimm),
        .vec_pc   (pc_next),
        .link_idx (link_idx),
        .link_val (link_data)
    );

    trap_status_upd #(.XW(XW)) u_msr (
        .take    (arb_take),
        .kind    (kind),
        .msr_in  (msr_in),
        .msr_out (msr_out)
    );

    trap_syndrome_regs #(.XW(XW), .CW(CW)) u_syn (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (arb_take),
        .kind       (kind),
        .dslot      (ctx_dslot),
        .btarget    (branch_tgt),
        .hw_cause   (hwexc_cause),
        .is_miss    (mmu_is_miss),
        .acc        (acc_type),
        .fault_addr (fault_addr),
        .esr_q      (esr_q),
        .ear_q      (ear_q),
        .btr_q      (btr_q)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (arb_take && kind == K_MMU) begin
                    state_d = ST_MMU_OPEN;
                end
            end
            ST_MMU_OPEN: begin
                if (recursive_hit) begin
                    state_d = ST_FATAL;
                end else if (arb_take && kind == K_MMU) begin
                    state_d = ST_MMU_OPEN;
                end else if (!msr_in[MSR_EIP]) begin
                    state_d = ST_RUN;
                end
            end
            ST_FATAL: state_d = ST_FATAL;
            default:  state_d = ST_RUN;
        endcase
    end

    // outputs
    always_comb begin
        take            = arb_take;
        entry_kind      = kind;
        link_we         = arb_take;
        resv_clear      = arb_take;
        ctx_clear       = arb_take;
        fatal_recursive = (state_q == ST_FATAL);
    end

endmodule

// File: rtl/trap_entry_checker.sv
module trap_entry_checker
    import trap_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        exc_supported,
    input logic        req_hwexc,
    input logic        req_irq,
    input logic [31:0] msr_in,
    input logic        ctx_dslot,
    input logic        ctx_imm,
    input logic        take,
    input logic [1:0]  entry_kind,
    input logic [31:0] msr_out,
    input logic [31:0] esr_q,
    input logic [31:0] ear_q,
    input logic        resv_clear,
    input logic        ctx_clear,
    input logic        fatal_recursive
);

    AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (take && entry_kind == 2'(K_IRQ)) |-> (msr_in[MSR_IE] && !msr_in[MSR_EIP] && !msr_in[MSR_BIP] && !ctx_dslot && !ctx_imm)); // R4

    AST_IRQ_IE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (take && entry_kind == 2'(K_IRQ)) |-> !msr_out[MSR_IE]); // R4

    AST_EIP_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (take && entry_kind[1]) |-> msr_out[MSR_EIP]); // R5

    AST_MODE_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (msr_out[MSR_UM+1] == msr_in[MSR_UM] && msr_out[MSR_VM+1] == msr_in[MSR_VM]
                  && !msr_out[MSR_UM] && !msr_out[MSR_VM])); // R6

    AST_FATAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_recursive |=> fatal_recursive); // R9

    AST_FATAL_NO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_recursive |-> !take); // R9

    AST_ENTRY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (resv_clear && ctx_clear)); // R10

    AST_HWEXC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (req_hwexc && exc_supported && !fatal_recursive) |-> (take && entry_kind == 2'(K_HWEXC))); // R11

    AST_NO_EXC_UNSUP: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_supported |-> !(take && entry_kind == 2'(K_HWEXC))); // R12

    AST_SYN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !entry_kind[1]) |=> ($stable(esr_q) && $stable(ear_q))); // R12

endmodule

bind trap_entry_ctrl trap_entry_checker u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .exc_supported   (exc_supported),
    .req_hwexc       (req_hwexc),
    .req_irq         (req_irq),
    .msr_in          (msr_in),
    .ctx_dslot       (ctx_dslot),
    .ctx_imm         (ctx_imm),
    .take            (take),
    .entry_kind      (entry_kind),
    .msr_out         (msr_out),
    .esr_q           (esr_q),
    .ear_q           (ear_q),
    .resv_clear      (resv_clear),
    .ctx_clear       (ctx_clear),
    .fatal_recursive (fatal_recursive)
);

// File: tb/trap_entry_ctrl_tb.sv
module trap_entry_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        b_sup = 1'b1, b_hw = 1'b0, b_mmu = 1'b0, b_miss = 1'b0;
    logic        b_brk = 1'b0, b_irq = 1'b0, b_ds = 1'b0, b_imm = 1'b0, b_bimm = 1'b0;
    logic [4:0]  b_cause = '0;
    logic [1:0]  b_acc = '0;
    logic [31:0] b_fa = '0, b_pc = '0, b_bt = '0, b_msr = '0;

    logic        take, link_we, resv_clear, ctx_clear, fatal_recursive;
    logic [1:0]  entry_kind;
    logic [4:0]  link_idx;
    logic [31:0] pc_next, link_data, msr_out, esr_q, ear_q, btr_q;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // bench model state
    int          m_st = 0;
    logic [31:0] m_esr = '0, m_ear = '0, m_btr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trap_entry_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .exc_supported(b_sup), .req_hwexc(b_hw),
        .hwexc_cause(b_cause), .req_mmu(b_mmu), .mmu_is_miss(b_miss), .acc_type(b_acc),
        .fault_addr(b_fa), .req_brk(b_brk), .req_irq(b_irq), .cur_pc(b_pc),
        .branch_tgt(b_bt), .msr_in(b_msr), .ctx_dslot(b_ds), .ctx_imm(b_imm),
        .ctx_bimm(b_bimm), .take(take), .entry_kind(entry_kind), .pc_next(pc_next),
        .link_we(link_we), .link_idx(link_idx), .link_data(link_data), .msr_out(msr_out),
        .esr_q(esr_q), .ear_q(ear_q), .btr_q(btr_q), .resv_clear(resv_clear),
        .ctx_clear(ctx_clear), .fatal_recursive(fatal_recursive)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    function automatic logic [31:0] vec_of(input int k);
        return (k == 0) ? 32'h10 : (k == 1) ? 32'h18 : 32'h20;
    endfunction

    task automatic clr_reqs();
        b_hw = 0; b_mmu = 0; b_brk = 0; b_irq = 0;
        b_ds = 0; b_imm = 0; b_bimm = 0; b_sup = 1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        clr_reqs();
        @(posedge clk); @(posedge clk); #1;
        rst_n = 1'b1;
        m_st = 0; m_esr = '0; m_ear = '0; m_btr = '0;
        #1;
        chk("R14 take after reset", {31'b0, take}, 32'd0);
        chk("R14 esr after reset", esr_q, 32'd0);
        chk("R14 ear after reset", ear_q, 32'd0);
        chk("R14 btr after reset", btr_q, 32'd0);
        chk("R14 fatal after reset", {31'b0, fatal_recursive}, 32'd0);
    endtask

    // one cycle: inputs already driven, just after a rising edge
    task automatic step(output logic o_take, output int o_kind);
        logic hw, irq_ok, busy, e_take, rec;
        int   k;
        logic [31:0] e_ret, e_msr, e_lidx;
        logic [4:0]  code;
        #1;
        hw     = b_hw && b_sup;
        irq_ok = b_irq && b_msr[1] && !b_msr[9] && !b_msr[3] && !b_ds && !b_imm;
        busy   = (m_st == 1) && b_msr[9];
        e_take = 0; k = 0; rec = 0;
        if (m_st != 2) begin
            if (hw) begin e_take = 1; k = 2; end
            else if (b_mmu) begin
                if (busy) rec = 1; else begin e_take = 1; k = 3; end
            end
            else if (b_brk) begin e_take = 1; k = 1; end
            else if (irq_ok) begin e_take = 1; k = 0; end
        end
        case (k)
            0: begin e_ret = b_pc; e_lidx = 14; end
            1: begin e_ret = b_pc; e_lidx = 16; end
            2: begin e_ret = b_pc + 4; e_lidx = 17; end
            default: begin
                e_lidx = 17;
                e_ret  = b_ds ? (b_bimm ? b_pc - 8 : b_pc - 4) : (b_imm ? b_pc - 4 : b_pc);
            end
        endcase
        e_msr = b_msr;
        if (e_take) begin
            if (k == 0) e_msr[1] = 1'b0;
            else if (k == 1) e_msr[3] = 1'b1;
            else e_msr[9] = 1'b1;
            e_msr[12] = e_msr[11]; e_msr[14] = e_msr[13];
            e_msr[11] = 1'b0;      e_msr[13] = 1'b0;
        end
        chk("R11/R12/R4 take", {31'b0, take}, {31'b0, e_take});
        chk("R10 resv_clear", {31'b0, resv_clear}, {31'b0, e_take});
        chk("R10 ctx_clear", {31'b0, ctx_clear}, {31'b0, e_take});
        chk("R2 link_we", {31'b0, link_we}, {31'b0, e_take});
        chk("R4/R5/R6 msr_out", msr_out, e_msr);
        if (e_take) begin
            chk("R1/R11 entry_kind", {30'b0, entry_kind}, k);
            chk("R1 pc_next", pc_next, vec_of(k));
            chk("R2 link_idx", {27'b0, link_idx}, e_lidx);
            chk("R2/R3 link_data", link_data, e_ret);
        end
        // predicted register updates
        if (e_take && k >= 2) begin
            code = (k == 3) ? (5'd16 + (b_miss ? 5'd2 : 5'd0) + ((b_acc == 2) ? 5'd1 : 5'd0)) : b_cause;
            m_esr = {19'b0, b_ds, 1'b0, (k == 3) && (b_acc == 1), 5'b0, code};
            if (b_ds) m_btr = b_bt;
            if (k == 3) m_ear = b_fa;
        end
        if (m_st == 0) begin
            if (e_take && k == 3) m_st = 1;
        end else if (m_st == 1) begin
            if (rec) m_st = 2;
            else if (e_take && k == 3) m_st = 1;
            else if (!b_msr[9]) m_st = 0;
        end
        @(posedge clk); #1;
        chk("R7/R8/R12 esr_q", esr_q, m_esr);
        chk("R8/R12 ear_q", ear_q, m_ear);
        chk("R7 btr_q", btr_q, m_btr);
        chk("R9/R13 fatal_recursive", {31'b0, fatal_recursive}, {31'b0, m_st == 2});
        if (e_take) b_msr = e_msr;
        o_take = e_take;
        o_kind = k;
    endtask

    initial begin
        logic t;
        int   k;
        void'($urandom(32'h5EED_1234));
        b_msr = 32'h0000_0002;
        b_pc  = 32'h0000_4000;
        do_reset();

        // interrupt accepted: IE set, clean context
        clr_reqs(); b_irq = 1; b_msr = 32'h0000_2802;
        step(t, k);
        chk("R4 irq accepted", {31'b0, t}, 32'd1);

        // interrupt blocked by delay slot
        clr_reqs(); b_irq = 1; b_ds = 1; b_msr = 32'h0000_0002;
        step(t, k);
        chk("R4 irq blocked in delay slot", {31'b0, take}, 32'd0);

        // management fault in an immediate-branch delay slot, data store miss
        clr_reqs(); b_mmu = 1; b_miss = 1; b_acc = 2'd1; b_ds = 1; b_bimm = 1;
        b_pc = 32'h0000_1000; b_bt = 32'hCAFE_0000; b_fa = 32'hDEAD_BEE0;
        step(t, k);
        chk("R3 rewind PC-8 seen", {31'b0, t}, 32'd1);
        chk("R8 store miss code", esr_q & 32'h0000_041F, 32'h0000_0412);

        // second fault while first is open: fatal
        clr_reqs(); b_mmu = 1;
        step(t, k);
        chk("R9 recursive blocks entry", {31'b0, t}, 32'd0);
        clr_reqs(); b_brk = 1;
        step(t, k);
        chk("R9 fatal blocks break", {31'b0, take}, 32'd0);
        do_reset();

        // unsupported exceptions ignored
        clr_reqs(); b_sup = 0; b_hw = 1; b_msr = 32'h0;
        step(t, k);
        chk("R12 unsupported exception ignored", {31'b0, take}, 32'd0);

        // everything pending: hardware exception wins
        clr_reqs(); b_hw = 1; b_cause = 5'd7; b_mmu = 1; b_brk = 1; b_irq = 1; b_msr = 32'h2;
        step(t, k);
        chk("R11 hwexc wins", k, 32'd2);

        // fault, then status cleared, then a new fault is normal
        clr_reqs(); b_msr = 32'h0; b_mmu = 1; b_imm = 1; b_acc = 2'd2;
        step(t, k);
        clr_reqs(); b_msr[9] = 1'b0;
        step(t, k);
        clr_reqs(); b_mmu = 1;
        step(t, k);
        chk("R13 new fault after clear accepted", {31'b0, t}, 32'd1);
        chk("R13 no fatal", {31'b0, fatal_recursive}, 32'd0);
        do_reset();

        for (int i = 0; i < N_RANDOM; i++) begin
            b_sup   = ($urandom % 8) != 0;
            b_hw    = ($urandom % 10) == 0;
            b_mmu   = ($urandom % 8) == 0;
            b_brk   = ($urandom % 8) == 0;
            b_irq   = ($urandom % 2) == 0;
            b_cause = 5'($urandom);
            b_miss  = 1'($urandom);
            b_acc   = 2'($urandom % 3);
            b_fa    = $urandom;
            b_pc    = $urandom & 32'hFFFF_FFFC;
            b_bt    = $urandom;
            case ($urandom % 4)
                0: begin b_ds = 1; b_imm = 0; b_bimm = 1'($urandom); end
                1: begin b_ds = 0; b_imm = 1; b_bimm = 0; end
                default: begin b_ds = 0; b_imm = 0; b_bimm = 0; end
            endcase
            if (($urandom % 4) == 0) begin
                b_msr[1]  = 1'($urandom);
                b_msr[3]  = 1'($urandom);
                b_msr[9]  = 1'($urandom);
                b_msr[11] = 1'($urandom);
                b_msr[13] = 1'($urandom);
            end
            step(t, k);
            if (m_st == 2) do_reset();
        end

        finish_run();
    end

endmodule